// File: doc/BRIEF.md
# Program Trace Status Encoder

This block sits beside a processor core and turns per-cycle retire events into a compact status code that external trace hardware samples every clock. A 3-bit flow code names the kind of instruction that retired. A 2-bit flush code marks the cycles spent in debug mode. A third output flags an instruction fetch as a program-trace cycle, which means its address must be shown on the external bus.

Non-branch instructions that change machine state (return from interrupt, machine-state writes, instruction synchronize, and writes to a set of debug and control registers) are reported as indirect branches, so that the address of the next fetch is exposed. Changes on the trace-window level input are announced in the code stream. A change that happens while the core is in debug mode is held back and announced in the first report after the core leaves debug mode.

Top module: `trc_status_enc`

## Requirements
- R1: After reset, the flow code is 000, the flush code is 00, and no trace mark is pending, so a fetch with show-all off is not marked.
- R2: The flow and flush codes are registered and change one clock edge after the retire inputs. Outside debug mode the flush code is 00. An idle cycle gives 000, a sequential retire gives 001, and a direct branch gives 010.
- R3: An exception gives 100 and an indirect branch gives 101. When several events arrive in one cycle, the priority is exception, then indirect, then window announcement, then direct branch, then sequential.
- R4: A retire on any enabled bit of the serializing-instruction vector is reported as 101, the same as an indirect branch.
- R5: Debug entry is reported as 100 in the first cycle. For as long as the core stays in debug mode after that, the codes are 000/11 and retire events have no effect. A debug-exit strobe outside debug mode has no effect.
- R6: On debug exit, if no window change is pending, the first report is 101.
- R7: On debug exit, if the window level toggled at any point during debug mode (or an announcement was already pending), the first report is 110. The pending announcement is then cleared.
- R8: A window-level change outside debug mode is reported as 110 in the same edge that sees it. If an exception or indirect branch takes that slot, the announcement waits. Only one announcement is held, and it is cleared when it is reported.
- R9: An exception, an indirect branch, a serializing instruction, a debug entry or a debug exit sets a trace mark. The next fetch is then marked regardless of show-all, even inside debug mode, and that fetch clears the mark.
- R10: With show-all on, every fetch outside debug mode is marked. With show-all off, or inside debug mode, a fetch with no pending mark is not marked.
- R11: With the default variant, a window announcement takes the slot from a direct-branch or sequential code in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rt_seq | input | 1 | Sequential instruction retired |
| rt_dir | input | 1 | Direct branch retired |
| rt_ind | input | 1 | Indirect branch retired |
| rt_exc | input | 1 | Exception or interrupt taken |
| rt_ser | input | N_SER | One bit per serializing instruction kind retired |
| dbg_enter | input | 1 | Core enters debug mode |
| dbg_exit | input | 1 | Core leaves debug mode |
| vsync | input | 1 | Trace window level |
| show_all | input | 1 | Mark every fetch as a trace cycle |
| fetch_req | input | 1 | Instruction fetch issued this cycle |
| vf | output | 3 | Instruction flow status code |
| vfls | output | 2 | Flush status code (11 in debug mode) |
| fetch_mark | output | 1 | Current fetch is a program-trace cycle |

## Verification
A window-level toggle can land in the same cycle as a retire event, and the two then compete for the single flow-code slot. The bench toggles the level together with a sequential retire, where the announcement must take the slot. It also toggles the level together with an indirect branch and with an exception, where the announcement must appear in the next idle slot. A second toggle while an announcement is already held must not produce a second one. Each queued expectation names the code the requirements dictate for that slot, and the monitor compares it one edge later. The same approach covers a fetch in the cycle after an event that sets the trace mark, where the mark has to win over a show-all setting that is off.

// File: rtl/trc_pkg.sv
package trc_pkg;

   localparam int VF_W   = 3;
   localparam int VFLS_W = 2;

   typedef enum logic [VF_W-1:0] {
      VF_NONE = 3'b000,
      VF_SEQ  = 3'b001,
      VF_DIR  = 3'b010,
      VF_EXC  = 3'b100,
      VF_IND  = 3'b101,
      VF_SYNC = 3'b110
   } vf_code_e;

   localparam logic [VFLS_W-1:0] FL_NONE = 2'b00;
   localparam logic [VFLS_W-1:0] FL_HALT = 2'b11;

   typedef enum logic {
      ST_RUN = 1'b0,
      ST_DBG = 1'b1
   } mode_e;

endpackage

// File: rtl/trc_sync_track.sv
module trc_sync_track (
   input  logic clk,
   input  logic rst_n,
   input  logic vsync,
   input  logic take,
   output logic want
);

   logic prev_q;
   logic pend_q;
   logic edge_w;

   assign edge_w = vsync ^ prev_q;
   assign want   = pend_q | edge_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         prev_q <= vsync;
         pend_q <= want & ~take;
      end
   end

   // R8
   sync_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (want && !take) |=> pend_q);

   // R7
   sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (pend_q == (vsync != $past(vsync))) || !pend_q);

endmodule

// File: rtl/trc_fetch_mark.sv
module trc_fetch_mark (
   input  logic clk,
   input  logic rst_n,
   input  logic mark_set,
   input  logic dbg,
   input  logic show_all,
   input  logic fetch_req,
   output logic fetch_mark
);

   logic pend_q;

   assign fetch_mark = fetch_req & (pend_q | (show_all & ~dbg));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= mark_set | (pend_q & ~fetch_req);
      end
   end

   // R9
   mark_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && fetch_req) |-> fetch_mark);

   // R9
   mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mark_set |=> pend_q);

   // R10
   mark_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (show_all && !dbg && fetch_req) |-> fetch_mark);

endmodule

// File: rtl/trc_flow_fsm.sv
module trc_flow_fsm
   import trc_pkg::*;
#(
   parameter int               N_SER      = 7,
   parameter logic [N_SER-1:0] SER_MASK   = '1,
   parameter int               YIELD_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rt_seq,
   input  logic              rt_dir,
   input  logic              rt_ind,
   input  logic              rt_exc,
   input  logic [N_SER-1:0]  rt_ser,
   input  logic              dbg_enter,
   input  logic              dbg_exit,
   input  logic              sync_want,
   output logic              sync_take,
   output logic              mark_set,
   output logic              dbg,
   output logic [VF_W-1:0]   vf,
   output logic [VFLS_W-1:0] vfls
);

   logic [N_SER-1:0] ser_hit;
   logic             ser_any;
   logic             ind_any;
   logic             sync_gate;

   generate
      for (genvar i = 0; i < N_SER; i++) begin : g_ser
         if (SER_MASK[i]) begin : g_on
            assign ser_hit[i] = rt_ser[i];
         end else begin : g_off
            assign ser_hit[i] = 1'b0;
         end
      end

      if (YIELD_SYNC == 0) begin : g_preempt
         assign sync_gate = 1'b1;
      end else begin : g_yield
         assign sync_gate = ~(rt_dir | rt_seq);
      end
   endgenerate

   assign ser_any = |ser_hit;
   assign ind_any = rt_ind | ser_any;

   mode_e             mode_q, mode_d;
   vf_code_e          vf_q, vf_d;
   logic [VFLS_W-1:0] vfls_q, vfls_d;

   always_comb begin
      mode_d    = mode_q;
      vf_d      = VF_NONE;
      vfls_d    = FL_NONE;
      sync_take = 1'b0;
      mark_set  = 1'b0;
      case (mode_q)
         ST_RUN: begin
            if (dbg_enter) begin
               mode_d   = ST_DBG;
               vf_d     = VF_EXC;
               mark_set = 1'b1;
            end else if (rt_exc) begin
               vf_d     = VF_EXC;
               mark_set = 1'b1;
            end else if (ind_any) begin
               vf_d     = VF_IND;
               mark_set = 1'b1;
            end else if (sync_want && sync_gate) begin
               vf_d      = VF_SYNC;
               sync_take = 1'b1;
            end else if (rt_dir) begin
               vf_d = VF_DIR;
            end else if (rt_seq) begin
               vf_d = VF_SEQ;
            end
         end
         default: begin
            if (dbg_exit) begin
               mode_d    = ST_RUN;
               mark_set  = 1'b1;
               sync_take = sync_want;
               vf_d      = sync_want ? VF_SYNC : VF_IND;
            end else begin
               vfls_d = FL_HALT;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= ST_RUN;
         vf_q   <= VF_NONE;
         vfls_q <= FL_NONE;
      end else begin
         mode_q <= mode_d;
         vf_q   <= vf_d;
         vfls_q <= vfls_d;
      end
   end

   assign dbg  = (mode_q == ST_DBG);
   assign vf   = vf_q;
   assign vfls = vfls_q;

   // R5
   enter_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ST_RUN && dbg_enter) |=> (vf_q == VF_EXC && mode_q == ST_DBG));

   // R5
   halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ST_DBG && !dbg_exit) |=> (vf_q == VF_NONE && vfls_q == FL_HALT));

   // R6
   exit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ST_DBG && dbg_exit) |=> (vf_q == VF_IND || vf_q == VF_SYNC));

   // R4
   ser_ind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ST_RUN && !dbg_enter && !rt_exc && ser_any) |=> vf_q == VF_IND);

   // R2
   run_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == ST_RUN) |-> vfls_q == FL_NONE);

endmodule

// File: rtl/trc_status_enc.sv
module trc_status_enc
   import trc_pkg::*;
#(
   parameter int               N_SER      = 7,
   parameter logic [N_SER-1:0] SER_MASK   = '1,
   parameter int               YIELD_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rt_seq,
   input  logic              rt_dir,
   input  logic              rt_ind,
   input  logic              rt_exc,
   input  logic [N_SER-1:0]  rt_ser,
   input  logic              dbg_enter,
   input  logic              dbg_exit,
   input  logic              vsync,
   input  logic              show_all,
   input  logic              fetch_req,
   output logic [VF_W-1:0]   vf,
   output logic [VFLS_W-1:0] vfls,
   output logic              fetch_mark
);

   generate
      if (N_SER < 1) begin : g_bad_nser
         $error("trc_status_enc: N_SER must be at least 1");
      end
      if (YIELD_SYNC != 0 && YIELD_SYNC != 1) begin : g_bad_yield
         $error("trc_status_enc: YIELD_SYNC must be 0 or 1");
      end
   endgenerate

   logic sync_want;
   logic sync_take;
   logic mark_set;
   logic dbg;

   trc_sync_track u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .vsync (vsync),
      .take  (sync_take),
      .want  (sync_want)
   );

   trc_flow_fsm #(
      .N_SER      (N_SER),
      .SER_MASK   (SER_MASK),
      .YIELD_SYNC (YIELD_SYNC)
   ) u_flow (
      .clk       (clk),
      .rst_n     (rst_n),
      .rt_seq    (rt_seq),
      .rt_dir    (rt_dir),
      .rt_ind    (rt_ind),
      .rt_exc    (rt_exc),
      .rt_ser    (rt_ser),
      .dbg_enter (dbg_enter),
      .dbg_exit  (dbg_exit),
      .sync_want (sync_want),
      .sync_take (sync_take),
      .mark_set  (mark_set),
      .dbg       (dbg),
      .vf        (vf),
      .vfls      (vfls)
   );

   trc_fetch_mark u_mark (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark_set   (mark_set),
      .dbg        (dbg),
      .show_all   (show_all),
      .fetch_req  (fetch_req),
      .fetch_mark (fetch_mark)
   );

   // R1
   reset_code_chk: assert property (@(posedge clk)
      !rst_n |=> (vf == 3'b000 && vfls == 2'b00));

endmodule

// File: tb/trc_status_enc_tb.sv
`timescale 1ns/1ps
module trc_status_enc_tb;

   localparam int N_SER = 7;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rt_seq = 0, rt_dir = 0, rt_ind = 0, rt_exc = 0;
   logic [N_SER-1:0] rt_ser = '0;
   logic             dbg_enter = 0, dbg_exit = 0, vsync = 0;
   logic             show_all = 0, fetch_req = 0;
   logic [2:0]       vf;
   logic [1:0]       vfls;
   logic             fetch_mark;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   trc_status_enc u_dut (
      .clk(clk), .rst_n(rst_n), .rt_seq(rt_seq), .rt_dir(rt_dir),
      .rt_ind(rt_ind), .rt_exc(rt_exc), .rt_ser(rt_ser),
      .dbg_enter(dbg_enter), .dbg_exit(dbg_exit), .vsync(vsync),
      .show_all(show_all), .fetch_req(fetch_req),
      .vf(vf), .vfls(vfls), .fetch_mark(fetch_mark)
   );

   typedef struct {
      logic [2:0] vf;
      logic [1:0] vfls;
      logic       mk;
      string      tag;
   } exp_t;

   exp_t q[$];

   // ev = {exc, ind, dir, seq}; ser_k < 0 means no serializing retire
   task automatic cyc(input logic [3:0] ev, input int ser_k, input logic en,
                      input logic ex, input logic vs, input logic fe, input logic sa,
                      input logic [2:0] evf, input logic [1:0] evfls,
                      input logic emk, input string tag);
      exp_t e;
      @(negedge clk);
      rt_exc    = ev[3];
      rt_ind    = ev[2];
      rt_dir    = ev[1];
      rt_seq    = ev[0];
      rt_ser    = (ser_k >= 0) ? (N_SER'(1) << ser_k) : '0;
      dbg_enter = en;
      dbg_exit  = ex;
      vsync     = vs;
      fetch_req = fe;
      show_all  = sa;
      e.vf = evf; e.vfls = evfls; e.mk = emk; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: fetch mark sampled before the edge, codes after it
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            logic mk;
            e  = q.pop_front();
            mk = fetch_mark;
            @(posedge clk);
            #1;
            check(e.tag, "vf", int'(vf), int'(e.vf));
            check(e.tag, "vfls", int'(vfls), int'(e.vfls));
            check(e.tag, "mark", int'(mk), int'(e.mk));
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   localparam logic [3:0] NO  = 4'b0000;
   localparam logic [3:0] SQ  = 4'b0001;
   localparam logic [3:0] DR  = 4'b0010;
   localparam logic [3:0] IN  = 4'b0100;
   localparam logic [3:0] EX  = 4'b1000;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state of registered codes
      check("R1", "vf", int'(vf), 0);
      check("R1", "vfls", int'(vfls), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: no pending mark after reset
      cyc(NO, -1, 0, 0, 0, 1, 0, 3'b000, 2'b00, 0, "R1");
      // R2 basic codes, R10 show-all
      cyc(NO, -1, 0, 0, 0, 0, 0, 3'b000, 2'b00, 0, "R2");
      cyc(SQ, -1, 0, 0, 0, 1, 1, 3'b001, 2'b00, 1, "R2_R10");
      cyc(DR, -1, 0, 0, 0, 1, 0, 3'b010, 2'b00, 0, "R2_R10");
      // R3 indirect, then R9 the next fetch is marked
      cyc(IN, -1, 0, 0, 0, 0, 0, 3'b101, 2'b00, 0, "R3");
      cyc(SQ, -1, 0, 0, 0, 1, 0, 3'b001, 2'b00, 1, "R9");
      cyc(SQ, -1, 0, 0, 0, 1, 0, 3'b001, 2'b00, 0, "R10");
      cyc(EX, -1, 0, 0, 0, 0, 0, 3'b100, 2'b00, 0, "R3");
      cyc(NO, -1, 0, 0, 0, 1, 0, 3'b000, 2'b00, 1, "R9");
      // R4 each serializing kind reported as indirect
      for (int k = 0; k < N_SER; k++)
         cyc(NO, k, 0, 0, 0, 1, 0, 3'b101, 2'b00, (k == 0) ? 1'b0 : 1'b1, "R4");
      cyc(NO, -1, 0, 0, 0, 1, 0, 3'b000, 2'b00, 1, "R9");
      // R3 priority among simultaneous events
      cyc(EX | IN, -1, 0, 0, 0, 0, 0, 3'b100, 2'b00, 0, "R3");
      cyc(IN | DR | SQ, -1, 0, 0, 0, 0, 0, 3'b101, 2'b00, 0, "R3");
      cyc(DR | SQ, -1, 0, 0, 0, 0, 0, 3'b010, 2'b00, 0, "R3");
      cyc(NO, -1, 0, 0, 0, 1, 0, 3'b000, 2'b00, 1, "R9");
      // R8 window change outside debug
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b110, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b00, 0, "R8");
      // R11 announcement takes the slot from a sequential retire
      cyc(SQ, -1, 0, 0, 0, 0, 0, 3'b110, 2'b00, 0, "R11");
      cyc(SQ, -1, 0, 0, 0, 0, 0, 3'b001, 2'b00, 0, "R11");
      // R8 announcement waits behind an indirect branch
      cyc(IN, -1, 0, 0, 1, 0, 0, 3'b101, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b110, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b00, 0, "R8");
      // R8 only one announcement held across two toggles
      cyc(EX, -1, 0, 0, 0, 0, 0, 3'b100, 2'b00, 0, "R8");
      cyc(IN, -1, 0, 0, 1, 0, 0, 3'b101, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b110, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b00, 0, "R8");
      cyc(NO, -1, 0, 0, 1, 1, 0, 3'b000, 2'b00, 1, "R9");
      // R5 debug entry and halt codes, R6 plain exit
      cyc(NO, -1, 1, 0, 1, 0, 0, 3'b100, 2'b00, 0, "R5");
      cyc(NO, -1, 0, 0, 1, 1, 1, 3'b000, 2'b11, 1, "R5_R9");
      cyc(NO, -1, 0, 0, 1, 1, 1, 3'b000, 2'b11, 0, "R10");
      cyc(IN, -1, 0, 0, 1, 0, 0, 3'b000, 2'b11, 0, "R5");
      cyc(NO, -1, 0, 1, 1, 0, 0, 3'b101, 2'b00, 0, "R6");
      cyc(NO, -1, 0, 0, 1, 1, 0, 3'b000, 2'b00, 1, "R9");
      // R7 window toggled inside debug, announced on exit
      cyc(NO, -1, 1, 0, 1, 0, 0, 3'b100, 2'b00, 0, "R7");
      cyc(NO, -1, 0, 0, 0, 0, 0, 3'b000, 2'b11, 0, "R7");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b11, 0, "R7");
      cyc(NO, -1, 0, 1, 1, 0, 0, 3'b110, 2'b00, 0, "R7");
      cyc(NO, -1, 0, 0, 1, 1, 0, 3'b000, 2'b00, 1, "R9");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b00, 0, "R7");
      // R5 exit strobe outside debug ignored
      cyc(NO, -1, 0, 1, 1, 0, 0, 3'b000, 2'b00, 0, "R5");
      cyc(NO, -1, 0, 0, 1, 0, 0, 3'b000, 2'b00, 0, "R5");

      repeat (4) @(posedge clk);
      #2;
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule